// File: doc/BRIEF.md
# Single-Slot Command Mailbox with Busy Interlock

This block is the handoff point between a host processor and a cell-processing engine. The host writes a command word to one register address. If the mailbox is idle, the low 31 bits of that word are latched as the command, and hardware sets a busy flag. The engine sees a one-cycle strobe that marks the new command. Only one command can be outstanding at a time.

While busy is set, the mailbox accepts no new command. A write to the mailbox with the top bit set is dropped. A write with the top bit clear is taken as firmware releasing the slot: busy clears and the latched command stays as it was. The engine never clears the flag itself. A read of the mailbox address returns the busy flag on top of the last accepted command. There is a single host, so there is no arbitration.

Top module: `cmd_mailbox`

## Requirements
- R1: After synchronous reset, busy is 0, the command output is 0, the strobe is 0 and a read of the mailbox returns 0.
- R2: A write to the mailbox address while busy is 0 latches write data bits 30..0 as the command, and busy reads 1 after that clock edge.
- R3: The strobe `cmd_new` is high for exactly the one cycle after the edge that accepted a command, and is low at all other times.
- R4: A mailbox write while busy is 1 with write data bit 31 equal to 1 is dropped: busy stays 1, the command is unchanged and no strobe is raised.
- R5: A mailbox write while busy is 1 with write data bit 31 equal to 0 clears busy. The command is unchanged and no strobe is raised.
- R6: Writes to any address other than the mailbox address change neither busy nor the command.
- R7: A read with the address equal to the mailbox address returns {busy, command}, with busy in bit 31. A read of any other address, or no read, returns 0.
- R8: Once busy has been cleared, the next mailbox write is accepted as a new command, including a write in the cycle right after the clear.
- R9: While idle, a mailbox write is accepted whatever the value of write data bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write enable |
| host_rd | input | 1 | Host read enable |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data (combinational) |
| cmd_field | output | DATA_W-1 | Last accepted command |
| cmd_new | output | 1 | One-cycle new-command strobe |
| busy | output | 1 | Busy flag |

## Verification
The bench builds the block with a 32-bit data word, a 4-bit address and the mailbox at address 6. With these values, neighbouring addresses can be used to show that decoding ignores them. The 32-bit word covers the full 31-bit command field, so all-ones and all-zero patterns can be driven, with bit 31 set or clear in both the idle and the busy state. The stimulus includes back-to-back clear-then-accept writes and a write that lands while the strobe is still high.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Action selected for one host write cycle
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_ACCEPT = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_DROP   = 2'd3
    } mbx_act_e;

    // Classify a write: hit on the mailbox, current busy, write bit 31
    function automatic mbx_act_e mbx_classify(input logic hit,
                                              input logic busy_now,
                                              input logic top_bit);
        mbx_act_e a;
        if (!hit)
            a = ACT_NONE;
        else if (!busy_now)
            a = ACT_ACCEPT;
        else if (!top_bit)
            a = ACT_CLEAR;
        else
            a = ACT_DROP;
        return a;
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int REG_ADDR = 6
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy_now,
    output mbx_act_e          act,
    output logic [DATA_W-2:0] cmd_in
);
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(REG_ADDR);

    logic hit;

    always_comb begin
        hit    = wr_en && (addr == SLOT);
        act    = mbx_classify(hit, busy_now, wdata[DATA_W-1]);
        cmd_in = wdata[DATA_W-2:0];
    end
endmodule

// File: rtl/mbx_store.sv
module mbx_store
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  mbx_act_e          act,
    input  logic [DATA_W-2:0] cmd_in,
    output logic              busy_q,
    output logic [DATA_W-2:0] cmd_q,
    output logic              new_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cmd_q  <= '0;
            new_q  <= 1'b0;
        end else begin
            new_q <= (act == ACT_ACCEPT);
            unique case (act)
                ACT_ACCEPT: begin
                    busy_q <= 1'b1;
                    cmd_q  <= cmd_in;
                end
                ACT_CLEAR: busy_q <= 1'b0;
                default: ;
            endcase
        end
    end

    assert_accept_latch_R2: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_ACCEPT) |=> (busy_q && cmd_q == $past(cmd_in)));

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
        new_q |=> !new_q);

    assert_strobe_busy_R3: assert property (@(posedge clk) disable iff (rst)
        new_q |-> busy_q);

    assert_drop_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_DROP) |=> (busy_q && $stable(cmd_q) && !new_q));

    assert_clear_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_CLEAR) |=> (!busy_q && $stable(cmd_q) && !new_q));

    assert_idle_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_NONE) |=> ($stable(busy_q) && $stable(cmd_q)));
endmodule

// File: rtl/mbx_readback.sv
module mbx_readback #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int REG_ADDR = 6
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy_now,
    input  logic [DATA_W-2:0] cmd_now,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(REG_ADDR);

    always_comb begin
        if (rd_en && addr == SLOT)
            rdata = {busy_now, cmd_now};
        else
            rdata = '0;
    end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int REG_ADDR = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [DATA_W-2:0] cmd_field,
    output logic              cmd_new,
    output logic              busy
);
    mbx_act_e          act;
    logic [DATA_W-2:0] cmd_in;

    mbx_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_decode (
        .wr_en    (host_wr),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .busy_now (busy),
        .act      (act),
        .cmd_in   (cmd_in)
    );

    mbx_store #(.DATA_W(DATA_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .act    (act),
        .cmd_in (cmd_in),
        .busy_q (busy),
        .cmd_q  (cmd_field),
        .new_q  (cmd_new)
    );

    mbx_readback #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_read (
        .rd_en    (host_rd),
        .addr     (host_addr),
        .busy_now (busy),
        .cmd_now  (cmd_field),
        .rdata    (host_rdata)
    );

    assert_read_view_R7: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_addr == ADDR_W'(REG_ADDR)) |-> host_rdata == {busy, cmd_field});

    assert_read_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !host_rd |-> host_rdata == '0);
endmodule

// File: tb/test_cmd_mailbox.sv
`timescale 1ns/1ps
module test_cmd_mailbox;
    localparam int AW   = 4;
    localparam int DW   = 32;
    localparam int SLOT = 6;

    typedef struct {
        logic          busy;
        logic [DW-2:0] cmd;
        logic          stb;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic [DW-2:0] cmd_field;
    logic          cmd_new;
    logic          busy;

    int   n_run  = 0;
    int   n_fail = 0;
    exp_t sb[$];
    logic          m_busy = 1'b0;
    logic [DW-2:0] m_cmd  = '0;

    always #2.5 clk = ~clk;

    cmd_mailbox #(.ADDR_W(AW), .DATA_W(DW), .REG_ADDR(SLOT)) i_cmd_mailbox (
        .clk, .rst, .host_wr, .host_rd, .host_addr, .host_wdata,
        .host_rdata, .cmd_field, .cmd_new, .busy
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one host cycle; pushes the expected post-edge state
    task automatic cyc(input logic wr, input logic rd, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input string tag);
        exp_t e;
        logic stb;
        @(negedge clk);
        host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d;
        #1;
        if (rd)
            chk({tag, " R7 read"}, host_rdata,
                (a == AW'(SLOT)) ? {m_busy, m_cmd} : '0);
        stb = 1'b0;
        if (wr && a == AW'(SLOT)) begin
            if (!m_busy) begin
                m_busy = 1'b1; m_cmd = d[DW-2:0]; stb = 1'b1;
            end else if (!d[DW-1]) begin
                m_busy = 1'b0;
            end
        end
        e.busy = m_busy; e.cmd = m_cmd; e.stb = stb; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " busy"}, DW'(busy), DW'(e.busy));
                chk({e.tag, " cmd"}, DW'(cmd_field), DW'(e.cmd));
                chk({e.tag, " strobe"}, DW'(cmd_new), DW'(e.stb));
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        host_rd = 1'b1; host_addr = AW'(SLOT);
        #1;
        chk("R1 reset busy", DW'(busy), '0);
        chk("R1 reset cmd", DW'(cmd_field), '0);
        chk("R1 reset strobe", DW'(cmd_new), '0);
        chk("R1 reset read", host_rdata, '0);

        cyc(1, 0, 4'h5, 32'h0000_0042, "R6 other addr idle");
        cyc(1, 0, 4'h7, 32'h8000_0043, "R6 other addr idle hi");
        cyc(1, 0, AW'(SLOT), 32'h8000_0123, "R2 accept");
        cyc(0, 1, AW'(SLOT), 32'h0, "R3 strobe drop");
        cyc(1, 0, AW'(SLOT), 32'hFFFF_FFFF, "R4 drop busy");
        cyc(1, 0, 4'h2, 32'h0000_0000, "R6 other addr busy");
        cyc(0, 1, 4'h5, 32'h0, "R7 other read");
        cyc(1, 0, AW'(SLOT), 32'h0000_0555, "R5 clear");
        cyc(0, 1, AW'(SLOT), 32'h0, "R5 read after clear");
        cyc(1, 0, AW'(SLOT), 32'h1234_5678, "R9 accept bit31 low");
        cyc(1, 0, AW'(SLOT), 32'h8765_4321, "R4 drop during strobe");
        cyc(1, 0, AW'(SLOT), 32'h7FFF_FFFF, "R5 clear again");
        cyc(1, 0, AW'(SLOT), 32'hFFFF_FFFF, "R8 accept after clear");
        cyc(1, 0, AW'(SLOT), 32'h0000_0000, "R5 clear all-ones kept");
        cyc(1, 0, AW'(SLOT), 32'h8000_0000, "R8 accept zero cmd");
        cyc(0, 1, AW'(SLOT), 32'h0, "R7 read busy");
        cyc(0, 0, 4'h0, 32'h0, "R3 idle");
        cyc(0, 0, 4'h0, 32'h0, "R7 no read");
        #1;
        chk("R7 no read zero", host_rdata, '0);
        @(posedge clk); #2;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule